// File: doc/BRIEF.md
# Variable-Period Scan Test Clock Sequencer

This block turns a stream of per-cycle scan test records into test clock, scan-in, primary-input and scan-enable waveforms for a circuit under test. A fast reference clock drives it, and each test cycle lasts a whole number of reference ticks. A host offers one record per test cycle with a valid/ready handshake. Each record holds a scan-in bit, primary-input values, a scan-enable value and the shortest period, in ticks, that the cycle may have without breaking the power budget. The block rounds that figure up to one of four programmed periods. It then plays the cycle out: the test clock is low for the first half of the period and high for the second half. At the end of the period the block captures the circuit's scan-out and primary outputs and returns them with a one-tick strobe.

A synchronous mode runs every cycle at the longest programmed period and disregards what the record asks for. This gives a fixed-rate baseline. A cycle count and a running sum of the ticks used let the host compare the test time of the two modes. During shift the host sends scan enable high. A capture cycle carries scan enable low for one record, and the response is shifted out in the records that follow. The block forwards these values as given.

Top module: `vp_scan_clkseq`

## Requirements
- R1: The period table holds four distinct entries in any order: entry k sits at bits [k*PW +: PW], and each entry is an even number of ticks, at least 4. A cycle uses the smallest entry that is at least the effective requirement, which is the largest of the record's required period, the floor, and twice the gap.
- R2: When the floor is larger than the record's requirement, no entry shorter than the floor is chosen.
- R3: The test clock's low half, half the chosen period, is never shorter than the programmed gap between input launch and the rising edge.
- R4: With sync mode high, every cycle uses the largest entry, whatever the record requires, and the violation flag is not set.
- R5: If the effective requirement is larger than every entry outside sync mode, the largest entry is used and the violation flag goes high. It stays high until reset.
- R6: For a chosen period P, the test clock is low for ticks 0 to P/2-1 of the cycle and high for ticks P/2 to P-1.
- R7: Scan-in, primary inputs and scan enable take the record's values from tick 0 of the cycle and hold them for the whole cycle.
- R8: The scan-out and primary outputs present at the last tick of a cycle are returned, with the response strobe high for one tick right after the cycle ends.
- R9: Ready is high when no cycle runs and during the last tick of a cycle, so records can follow one another without a gap. With no record available, the test clock stays low.
- R10: The cycle count rises by one for each accepted record, and the tick total rises by that cycle's chosen period.
- R11: After reset the test clock, the strobe, the violation flag and both counters are zero, and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_tbl_i | input | 4*PW | Four programmed periods, entry k at [k*PW +: PW] |
| floor_i | input | PW | Critical-path minimum period in ticks |
| gap_i | input | PW | Minimum ticks between input launch and rising edge |
| sync_i | input | 1 | Fixed-period mode: always the longest entry |
| rec_valid_i | input | 1 | Record offered |
| rec_ready_o | output | 1 | Record accepted on this edge when valid |
| rec_si_i | input | 1 | Record scan-in bit |
| rec_pi_i | input | NPI | Record primary-input values |
| rec_se_i | input | 1 | Record scan-enable value |
| rec_req_i | input | PW | Record minimum period in ticks |
| tck_o | output | 1 | Test clock to the circuit |
| scan_in_o | output | 1 | Scan-in to the circuit |
| pi_o | output | NPI | Primary inputs to the circuit |
| se_o | output | 1 | Scan enable to the circuit |
| scan_out_i | input | 1 | Scan-out from the circuit |
| po_i | input | NPO | Primary outputs from the circuit |
| resp_valid_o | output | 1 | Response strobe |
| resp_so_o | output | 1 | Captured scan-out |
| resp_po_o | output | NPO | Captured primary outputs |
| viol_o | output | 1 | Sticky flag: a requirement exceeded every entry |
| cyc_cnt_o | output | CW | Test cycles started |
| tick_sum_o | output | TW | Total ticks across started cycles |

## Verification
The bench builds the block with its defaults: 8-bit periods, four primary inputs and outputs, and a period table of 6, 10, 16 and 24 ticks, stored out of order. At that size a sweep of every required period from 0 to 26 can run under each pairing of two floors, two gaps and both modes. Every branch of the rounding is reached this way: exact hits, rounding up, the floor winning, the gap winning, sync mode and overflow. Each cycle is followed tick by tick for clock shape, held inputs and the response. Directed cases cover the sticky flag and back-to-back records.

// File: rtl/vpsc_pkg.sv
package vpsc_pkg;

    // How the period of a cycle was chosen
    typedef enum logic [1:0] {
        PICK_FIT  = 2'd0,
        PICK_SYNC = 2'd1,
        PICK_MISS = 2'd2
    } pick_kind_e;

    localparam int unsigned NPER = 4;

endpackage

// File: rtl/vpsc_period_pick.sv
module vpsc_period_pick
    import vpsc_pkg::*;
#(
    parameter int unsigned PW = 8
) (
    input  logic [NPER*PW-1:0] per_tbl_i,
    input  logic [PW-1:0]      req_i,
    input  logic [PW-1:0]      floor_i,
    input  logic [PW-1:0]      gap_i,
    input  logic               sync_i,
    output logic [PW-1:0]      per_o,
    output pick_kind_e         kind_o
);

    localparam int unsigned EW = PW + 1;

    logic [PW-1:0] ent [NPER];

    for (genvar k = 0; k < NPER; k++) begin : g_ent
        assign ent[k] = per_tbl_i[k*PW +: PW];
    end

    logic [EW-1:0] eff;
    logic [EW-1:0] best;
    logic [PW-1:0] longest;
    logic          found;

    always_comb begin
        eff = {1'b0, req_i};
        if ({1'b0, floor_i} > eff) eff = {1'b0, floor_i};
        if ({gap_i, 1'b0} > eff)   eff = {gap_i, 1'b0};

        best    = '1;
        found   = 1'b0;
        longest = '0;
        for (int k = 0; k < NPER; k++) begin
            if (({1'b0, ent[k]} >= eff) && ({1'b0, ent[k]} < best)) begin
                best  = {1'b0, ent[k]};
                found = 1'b1;
            end
            if (ent[k] > longest) longest = ent[k];
        end

        if (sync_i) begin
            per_o  = longest;
            kind_o = PICK_SYNC;
        end else if (found) begin
            per_o  = best[PW-1:0];
            kind_o = PICK_FIT;
        end else begin
            per_o  = longest;
            kind_o = PICK_MISS;
        end
    end

endmodule

// File: rtl/vpsc_tally.sv
module vpsc_tally #(
    parameter int unsigned PW = 8,
    parameter int unsigned CW = 16,
    parameter int unsigned TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [PW-1:0] per_i,
    output logic [CW-1:0] cyc_o,
    output logic [TW-1:0] ticks_o
);

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [TW-1:0] ticks;
    } tally_t;

    tally_t tally_d, tally_q;

    always_comb begin
        tally_d = tally_q;
        if (start_i) begin
            tally_d.cyc   = tally_q.cyc + 1'b1;
            tally_d.ticks = tally_q.ticks + {{(TW-PW){1'b0}}, per_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tally_q <= '0;
        else        tally_q <= tally_d;
    end

    assign cyc_o   = tally_q.cyc;
    assign ticks_o = tally_q.ticks;

    // R10
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o != $past(cyc_o)) |-> (cyc_o == $past(cyc_o) + 1'b1));

    // R10
    tick_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o == $past(cyc_o)) |-> (ticks_o == $past(ticks_o)));

endmodule

// File: rtl/vp_scan_clkseq.sv
module vp_scan_clkseq
    import vpsc_pkg::*;
#(
    parameter int unsigned PW  = 8,
    parameter int unsigned NPI = 4,
    parameter int unsigned NPO = 4,
    parameter int unsigned CW  = 16,
    parameter int unsigned TW  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPER*PW-1:0] per_tbl_i,
    input  logic [PW-1:0]      floor_i,
    input  logic [PW-1:0]      gap_i,
    input  logic               sync_i,
    input  logic               rec_valid_i,
    output logic               rec_ready_o,
    input  logic               rec_si_i,
    input  logic [NPI-1:0]     rec_pi_i,
    input  logic               rec_se_i,
    input  logic [PW-1:0]      rec_req_i,
    output logic               tck_o,
    output logic               scan_in_o,
    output logic [NPI-1:0]     pi_o,
    output logic               se_o,
    input  logic               scan_out_i,
    input  logic [NPO-1:0]     po_i,
    output logic               resp_valid_o,
    output logic               resp_so_o,
    output logic [NPO-1:0]     resp_po_o,
    output logic               viol_o,
    output logic [CW-1:0]      cyc_cnt_o,
    output logic [TW-1:0]      tick_sum_o
);

    typedef struct packed {
        logic           active;
        logic [PW-1:0]  tick;
        logic [PW-1:0]  per;
        pick_kind_e     kind;
        logic           tck;
        logic           si;
        logic [NPI-1:0] pi;
        logic           se;
        logic           rv;
        logic           rso;
        logic [NPO-1:0] rpo;
        logic           viol;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [PW-1:0] pick_per;
    pick_kind_e    pick_kind;
    logic          last_tick;
    logic          take;

    vpsc_period_pick #(.PW(PW)) u_pick (
        .per_tbl_i (per_tbl_i),
        .req_i     (rec_req_i),
        .floor_i   (floor_i),
        .gap_i     (gap_i),
        .sync_i    (sync_i),
        .per_o     (pick_per),
        .kind_o    (pick_kind)
    );

    assign last_tick   = seq_q.active && (seq_q.tick == seq_q.per - 1'b1);
    assign rec_ready_o = !seq_q.active || last_tick;
    assign take        = rec_ready_o && rec_valid_i;

    always_comb begin
        seq_d    = seq_q;
        seq_d.rv = 1'b0;

        if (seq_q.active && !last_tick) seq_d.tick = seq_q.tick + 1'b1;

        if (last_tick) begin
            seq_d.rv     = 1'b1;
            seq_d.rso    = scan_out_i;
            seq_d.rpo    = po_i;
            seq_d.active = 1'b0;
            seq_d.tick   = '0;
        end

        if (take) begin
            seq_d.active = 1'b1;
            seq_d.tick   = '0;
            seq_d.per    = pick_per;
            seq_d.kind   = pick_kind;
            seq_d.si     = rec_si_i;
            seq_d.pi     = rec_pi_i;
            seq_d.se     = rec_se_i;
            if (pick_kind == PICK_MISS) seq_d.viol = 1'b1;
        end

        seq_d.tck = seq_d.active && (seq_d.tick >= (seq_d.per >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    vpsc_tally #(.PW(PW), .CW(CW), .TW(TW)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (take),
        .per_i   (pick_per),
        .cyc_o   (cyc_cnt_o),
        .ticks_o (tick_sum_o)
    );

    assign tck_o        = seq_q.tck;
    assign scan_in_o    = seq_q.si;
    assign pi_o         = seq_q.pi;
    assign se_o         = seq_q.se;
    assign resp_valid_o = seq_q.rv;
    assign resp_so_o    = seq_q.rso;
    assign resp_po_o    = seq_q.rpo;
    assign viol_o       = seq_q.viol;

    // R7
    inputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && seq_q.tick != '0) |->
            ($stable(pi_o) && $stable(se_o) && $stable(scan_in_o)));

    // R6
    tck_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck_o) |-> (seq_q.tick == (seq_q.per >> 1)));

    // R9
    stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.active |-> !tck_o);

    // R5
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(viol_o) |-> viol_o);

    // R8
    resp_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |-> !$past(resp_valid_o));

    // R2
    floor_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && seq_q.kind == PICK_FIT) |-> (seq_q.per >= floor_i));

    // R3
    gap_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && seq_q.kind == PICK_FIT) |-> ((seq_q.per >> 1) >= gap_i));

endmodule

// File: tb/tb_vp_scan_clkseq.sv
module tb_vp_scan_clkseq;

    localparam int unsigned PW  = 8;
    localparam int unsigned NPI = 4;
    localparam int unsigned NPO = 4;
    localparam int unsigned CW  = 16;
    localparam int unsigned TW  = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4*PW-1:0] per_tbl;
    logic [PW-1:0]   floor_v = '0;
    logic [PW-1:0]   gap_v = 8'd2;
    logic            sync_v = 1'b0;
    logic            rec_valid = 1'b0;
    logic            rec_ready;
    logic            rec_si = 1'b0;
    logic [NPI-1:0]  rec_pi = '0;
    logic            rec_se = 1'b0;
    logic [PW-1:0]   rec_req = '0;
    logic            tck, scan_in, se, scan_out;
    logic [NPI-1:0]  pi;
    logic [NPO-1:0]  po;
    logic            resp_valid, resp_so, viol;
    logic [NPO-1:0]  resp_po;
    logic [CW-1:0]   cyc_cnt;
    logic [TW-1:0]   tick_sum;

    int n_chk = 0;
    int n_bad = 0;
    int n_rec = 0;
    int sum_exp = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    // entry3=10, entry2=24, entry1=6, entry0=16
    assign per_tbl = {8'd10, 8'd24, 8'd6, 8'd16};

    // simple circuit model
    assign po       = ~pi;
    assign scan_out = scan_in ^ se;

    vp_scan_clkseq #(.PW(PW), .NPI(NPI), .NPO(NPO), .CW(CW), .TW(TW)) dut (
        .clk (clk), .rst_n (rst_n), .per_tbl_i (per_tbl), .floor_i (floor_v),
        .gap_i (gap_v), .sync_i (sync_v), .rec_valid_i (rec_valid),
        .rec_ready_o (rec_ready), .rec_si_i (rec_si), .rec_pi_i (rec_pi),
        .rec_se_i (rec_se), .rec_req_i (rec_req), .tck_o (tck),
        .scan_in_o (scan_in), .pi_o (pi), .se_o (se), .scan_out_i (scan_out),
        .po_i (po), .resp_valid_o (resp_valid), .resp_so_o (resp_so),
        .resp_po_o (resp_po), .viol_o (viol), .cyc_cnt_o (cyc_cnt),
        .tick_sum_o (tick_sum)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_req(input int req);
        int e = req;
        if (int'(floor_v) > e) e = int'(floor_v);
        if (2 * int'(gap_v) > e) e = 2 * int'(gap_v);
        return e;
    endfunction

    function automatic int exp_per(input int req);
        int e = eff_req(req);
        if (sync_v) return 24;
        if (e <= 6)  return 6;
        if (e <= 10) return 10;
        if (e <= 16) return 16;
        return 24;
    endfunction

    function automatic string tag_of(input int req);
        int e = eff_req(req);
        if (sync_v) return "R4";
        if (e > 24) return "R5";
        if (int'(floor_v) > req && int'(floor_v) >= 2 * int'(gap_v)) return "R2";
        if (2 * int'(gap_v) > req && 2 * int'(gap_v) > int'(floor_v)) return "R3";
        return "R1";
    endfunction

    task automatic run_rec(input bit si_b, input logic [NPI-1:0] pi_b, input bit se_b, input int req);
        int p = exp_per(req);
        string tg = tag_of(req);
        int bad_shape = 0;
        int bad_hold = 0;
        int low_seen = 0;
        @(negedge clk);
        while (!rec_ready) @(negedge clk);
        rec_si = si_b; rec_pi = pi_b; rec_se = se_b; rec_req = PW'(req);
        rec_valid = 1'b1;
        @(posedge clk);
        #1 rec_valid = 1'b0;
        for (int t = 0; t < p; t++) begin
            @(negedge clk);
            if (tck !== (t >= p / 2)) bad_shape++;
            if (!tck) low_seen++;
            if (pi !== pi_b || se !== se_b || scan_in !== si_b) bad_hold++;
            if (resp_valid !== 1'b0) bad_shape++;
        end
        // R6 clock shape over the chosen period
        chk(bad_shape == 0, "R6", bad_shape, 0);
        // R3 low half never shorter than the gap
        chk(low_seen >= int'(gap_v), "R3", low_seen, gap_v);
        // R7 inputs held
        chk(bad_hold == 0, "R7", bad_hold, 0);
        @(negedge clk);
        // period length checked by strobe arrival (R1/R2/R3/R4/R5)
        chk(resp_valid === 1'b1, tg, resp_valid, 1);
        // R8 response content
        chk(resp_po === ~pi_b && resp_so === (si_b ^ se_b), "R8",
            {resp_so, resp_po}, {si_b ^ se_b, ~pi_b});
        // R9 stall low, ready when idle
        chk(tck === 1'b0 && rec_ready === 1'b1, "R9", {tck, rec_ready}, 1);
        n_rec++;
        sum_exp += p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(tck === 0 && resp_valid === 0 && viol === 0, "R11", {tck, resp_valid, viol}, 0);
        chk(cyc_cnt === 0 && tick_sum === 0, "R11", cyc_cnt + tick_sum, 0);
        chk(rec_ready === 1'b1, "R11", rec_ready, 1);

        // R4: sync ignores an oversized requirement, no violation
        sync_v = 1'b1;
        run_rec(1'b1, 4'h3, 1'b1, 40);
        chk(viol === 1'b0, "R4", viol, 0);
        sync_v = 1'b0;
        run_rec(1'b0, 4'h5, 1'b1, 20);
        chk(viol === 1'b0, "R5", viol, 0);
        // R5: miss sets the flag, which stays set
        run_rec(1'b1, 4'h9, 1'b0, 30);
        chk(viol === 1'b1, "R5", viol, 1);
        run_rec(1'b0, 4'h1, 1'b1, 2);
        chk(viol === 1'b1, "R5", viol, 1);

        // R9 back-to-back records
        @(negedge clk);
        while (!rec_ready) @(negedge clk);
        rec_pi = 4'h1; rec_si = 1'b0; rec_se = 1'b1; rec_req = 8'd5;
        rec_valid = 1'b1;
        @(posedge clk);
        #1 rec_pi = 4'h2;
        for (int t = 0; t < 6; t++) @(negedge clk);
        chk(rec_ready === 1'b1, "R9", rec_ready, 1);
        @(posedge clk);
        #1 rec_valid = 1'b0;
        @(negedge clk);
        chk(resp_valid === 1'b1 && resp_po === 4'hE, "R9", {resp_valid, resp_po}, {1'b1, 4'hE});
        chk(pi === 4'h2 && tck === 1'b0, "R9", {pi, tck}, {4'h2, 1'b0});
        n_rec += 2;
        sum_exp += 12;
        repeat (6) @(negedge clk);

        // sweep: modes x floors x gaps x required periods
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 2; f++) begin
                for (int g = 0; g < 2; g++) begin
                    sync_v  = m[0];
                    floor_v = (f == 0) ? 8'd0 : 8'd12;
                    gap_v   = (g == 0) ? 8'd2 : 8'd4;
                    for (int r = 0; r <= 26; r++) begin
                        run_rec(r[0], NPI'(r), r[1], r);
                    end
                end
            end
        end

        // R10 counters
        @(negedge clk);
        chk(cyc_cnt == CW'(n_rec), "R10", cyc_cnt, n_rec);
        chk(tick_sum == TW'(sum_exp), "R10", tick_sum, sum_exp);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule